// File: doc/BRIEF.md
# T1/E1 Transmit Channel Timing Generator

This block derives the transmit-side timing strobes of a T1 or E1 framer from one bit clock. The bit clock runs at 1.544 MHz in T1 mode and at 2.048 MHz in E1 mode. The block keeps a bit-in-channel counter, a channel counter and a frame-in-multiframe counter. A two-state machine tracks where the current bit lies in the frame. All three outputs are decoded combinationally from this state, so each output describes the bit that is on the line during the current clock period.

The two states are `ST_FRAMING` and `ST_PAYLOAD`. `ST_FRAMING` covers the single T1 framing bit. `ST_PAYLOAD` covers the eight bits of every channel. The state machine has these transitions:
- "enter payload": `ST_FRAMING` to `ST_PAYLOAD`, after one bit.
- "advance": `ST_PAYLOAD` to `ST_PAYLOAD`, on any bit other than the last bit of the frame.
- "close T1 frame": `ST_PAYLOAD` to `ST_FRAMING`, after bit 8 of the last channel in T1 mode.
- "wrap E1 frame": `ST_PAYLOAD` to `ST_PAYLOAD`, after bit 8 of channel 31 in E1 mode, with the counters cleared.
- "reload": from any state, on reset or on a sync pulse. It goes to `ST_FRAMING` in T1 mode and to `ST_PAYLOAD` in E1 mode.

The channel strobe has two modes. In pulse mode it marks the last bit of every channel, which gives a rate of 192 kHz in T1 and 256 kHz in E1. In gated mode it acts as a bit-clock enable for fractional service. The channel-block marker is programmable per channel. The sync output pulses either on every frame or only on every multiframe. In T1 frame mode it can widen to two bits on the signaling frames.

Top module: `tx_chan_timing`

## Requirements
- R1: When `rst` or `sync_in` is high at a rising edge, the following cycle is bit 1 of frame 1. In T1 this is the framing bit. In E1 it is bit 1 of channel 0.
- R2: A T1 frame lasts 193 cycles: one framing bit, then 24 channels of 8 bits. An E1 frame lasts 256 cycles: 32 channels of 8 bits. With `mf_sync=0` and `wide_sig=0`, successive `sync_out` pulses are therefore 193 or 256 cycles apart.
- R3: With `gate_mode=0`, `chan_strobe` is high only on bit 8 (the last bit) of each channel.
- R4: With `gate_mode=1`, `chan_strobe` is high on all 8 bits of channel n when `frac_mask[n]` is 1, and low otherwise. Channel 0 is the first channel after the framing bit.
- R5: `chan_block` is high for all 8 bits of channel n exactly when `blk_mask[n]` is 1.
- R6: During the T1 framing bit, `chan_strobe` and `chan_block` are low whatever the masks hold.
- R7: With `mf_sync=0`, `sync_out` is high on the first bit of every frame.
- R8: With `mf_sync=1`, `sync_out` is high only on the first bit of frame 1 of each multiframe. A multiframe is 24 frames in T1 and 16 frames in E1. `wide_sig` has no effect in this mode.
- R9: In T1 mode with `mf_sync=0` and `wide_sig=1`, on frames 6, 12, 18 and 24 `sync_out` stays high for two bits: the framing bit and bit 1 of channel 0. On all other frames it is one bit wide. In E1 mode `wide_sig` has no effect.
- R10: In T1 mode, bits 31..24 of `blk_mask` and `frac_mask` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| e1_mode | input | 1 | 1 selects E1 timing, 0 selects T1 |
| sync_in | input | 1 | External sync pulse, reloads the counters |
| gate_mode | input | 1 | 1 makes the strobe a gated bit-clock enable |
| mf_sync | input | 1 | 1 selects multiframe pulses on `sync_out` |
| wide_sig | input | 1 | Widens the T1 frame pulse on signaling frames |
| blk_mask | input | 32 | Channel-block marker, bit n for channel n |
| frac_mask | input | 32 | Gated-mode channel enables, bit n for channel n |
| chan_strobe | output | 1 | Channel strobe or gated clock enable |
| chan_block | output | 1 | Per-channel block marker |
| sync_out | output | 1 | Frame or multiframe sync |

## Verification
The widened second sync bit on a T1 signaling frame falls in the same cycle as the first bit of channel 0. In that cycle the block marker and the gated strobe for channel 0 may also be active. The bench provokes this overlap by running a full T1 multiframe in wide frame-sync mode with gated strobes and with bit 0 of both masks set. It then checks in every cycle that all three outputs are high together on frames 6, 12, 18 and 24, and that only the channel outputs are high on the other frames. A second overlap is an external sync that arrives in the middle of a channel. The bench checks that the reload takes priority over the normal advance.

// File: rtl/tct_pkg.sv
package tct_pkg;
    typedef enum logic [0:0] {
        ST_FRAMING = 1'b0,
        ST_PAYLOAD = 1'b1
    } tct_state_e;
endpackage

// File: rtl/tct_chan_ctr.sv
module tct_chan_ctr
    import tct_pkg::*;
#(
    parameter int CH_BITS  = 8,
    parameter int T1_CHANS = 24,
    parameter int E1_CHANS = 32,
    localparam int BW = $clog2(CH_BITS),
    localparam int CW = $clog2(E1_CHANS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_in,
    input  logic          e1_mode,
    output tct_state_e    state,
    output logic [BW-1:0] bit_idx,
    output logic [CW-1:0] chan_idx,
    output logic          frame_end
);
    localparam logic [BW-1:0] BIT_LAST = BW'(CH_BITS - 1);
    localparam logic [CW-1:0] T1_LAST  = CW'(T1_CHANS - 1);
    localparam logic [CW-1:0] E1_LAST  = CW'(E1_CHANS - 1);

    tct_state_e    nxt_state;
    logic [BW-1:0] nxt_bit;
    logic [CW-1:0] nxt_chan;
    logic [CW-1:0] last_chan;
    logic          restart;

    assign restart   = rst | sync_in;
    assign last_chan = e1_mode ? E1_LAST : T1_LAST;

    // state register
    always_ff @(posedge clk) begin
        state    <= nxt_state;
        bit_idx  <= nxt_bit;
        chan_idx <= nxt_chan;
    end

    // next-state and transition decode
    always_comb begin
        nxt_state = state;
        nxt_bit   = bit_idx;
        nxt_chan  = chan_idx;
        frame_end = 1'b0;
        if (restart) begin
            nxt_state = e1_mode ? ST_PAYLOAD : ST_FRAMING;
            nxt_bit   = '0;
            nxt_chan  = '0;
        end else begin
            unique case (state)
                ST_FRAMING: begin
                    nxt_state = ST_PAYLOAD;
                    nxt_bit   = '0;
                    nxt_chan  = '0;
                end
                ST_PAYLOAD: begin
                    if (bit_idx == BIT_LAST) begin
                        nxt_bit = '0;
                        if (chan_idx >= last_chan) begin
                            nxt_chan  = '0;
                            frame_end = 1'b1;
                            nxt_state = e1_mode ? ST_PAYLOAD : ST_FRAMING;
                        end else begin
                            nxt_chan = chan_idx + 1'b1;
                        end
                    end else begin
                        nxt_bit = bit_idx + 1'b1;
                    end
                end
                default: nxt_state = ST_FRAMING;
            endcase
        end
    end

    // R1: a sync pulse puts the next cycle on the first bit of channel 0
    a_r1_sync_reload: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (bit_idx == '0 && chan_idx == '0));

    // R3: inside a channel the bit counter steps by one
    a_r3_bit_step: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && state == ST_PAYLOAD && bit_idx != BIT_LAST)
            |=> (bit_idx == $past(bit_idx) + 1'b1));

    // R2: a T1 frame close is followed by the framing bit
    a_r2_t1_close: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !e1_mode) |=> (sync_in || e1_mode || state == ST_FRAMING));
endmodule

// File: rtl/tct_frame_ctr.sv
module tct_frame_ctr #(
    parameter int T1_MF     = 24,
    parameter int E1_MF     = 16,
    parameter int SIG_EVERY = 6,
    localparam int MF_MAX   = (T1_MF > E1_MF) ? T1_MF : E1_MF,
    localparam int FW       = $clog2(MF_MAX),
    localparam int SW       = $clog2(SIG_EVERY)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_in,
    input  logic          e1_mode,
    input  logic          frame_end,
    output logic [FW-1:0] frm_idx,
    output logic          sig_frame
);
    localparam logic [FW-1:0] T1_FLAST = FW'(T1_MF - 1);
    localparam logic [FW-1:0] E1_FLAST = FW'(E1_MF - 1);
    localparam logic [SW-1:0] SIG_LAST = SW'(SIG_EVERY - 1);

    logic [SW-1:0] sig_cnt;
    logic [SW-1:0] nxt_sig;
    logic [FW-1:0] nxt_frm;
    logic [FW-1:0] last_frm;

    assign last_frm = e1_mode ? E1_FLAST : T1_FLAST;

    always_ff @(posedge clk) begin
        frm_idx <= nxt_frm;
        sig_cnt <= nxt_sig;
    end

    always_comb begin
        nxt_frm = frm_idx;
        nxt_sig = sig_cnt;
        if (rst || sync_in) begin
            nxt_frm = '0;
            nxt_sig = '0;
        end else if (frame_end) begin
            if (frm_idx >= last_frm) begin
                nxt_frm = '0;
                nxt_sig = '0;
            end else begin
                nxt_frm = frm_idx + 1'b1;
                nxt_sig = (sig_cnt == SIG_LAST) ? '0 : sig_cnt + 1'b1;
            end
        end
    end

    assign sig_frame = !e1_mode && (sig_cnt == SIG_LAST);

    // R9: signaling frames are every sixth frame counted from frame 1
    a_r9_sig_phase: assert property (@(posedge clk) disable iff (rst)
        sig_frame |-> (((int'(frm_idx) + 1) % SIG_EVERY) == 0));

    // R8: the frame counter stays inside the multiframe
    a_r8_frame_bound: assert property (@(posedge clk) disable iff (rst)
        int'(frm_idx) < MF_MAX);
endmodule

// File: rtl/tct_strobe_gen.sv
module tct_strobe_gen
    import tct_pkg::*;
#(
    parameter int CH_BITS  = 8,
    parameter int E1_CHANS = 32,
    parameter int MF_MAX   = 24,
    localparam int BW = $clog2(CH_BITS),
    localparam int CW = $clog2(E1_CHANS),
    localparam int FW = $clog2(MF_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  tct_state_e          state,
    input  logic [BW-1:0]       bit_idx,
    input  logic [CW-1:0]       chan_idx,
    input  logic [FW-1:0]       frm_idx,
    input  logic                sig_frame,
    input  logic                e1_mode,
    input  logic                gate_mode,
    input  logic                mf_sync,
    input  logic                wide_sig,
    input  logic [E1_CHANS-1:0] blk_mask,
    input  logic [E1_CHANS-1:0] frac_mask,
    output logic                chan_strobe,
    output logic                chan_block,
    output logic                sync_out
);
    localparam logic [BW-1:0] BIT_LAST = BW'(CH_BITS - 1);

    logic at_ch0_bit0;
    logic first_bit;
    logic second_bit;

    assign at_ch0_bit0 = (chan_idx == '0) && (bit_idx == '0);

    // output decode
    always_comb begin
        chan_strobe = 1'b0;
        chan_block  = 1'b0;
        first_bit   = 1'b0;
        second_bit  = 1'b0;
        unique case (state)
            ST_FRAMING: begin
                first_bit = 1'b1;
            end
            ST_PAYLOAD: begin
                chan_strobe = gate_mode ? frac_mask[chan_idx]
                                        : (bit_idx == BIT_LAST);
                chan_block  = blk_mask[chan_idx];
                first_bit   = e1_mode && at_ch0_bit0;
                second_bit  = !e1_mode && at_ch0_bit0;
            end
            default: ;
        endcase
        if (mf_sync)
            sync_out = first_bit && (frm_idx == '0);
        else
            sync_out = first_bit || (wide_sig && sig_frame && second_bit);
    end

    // R6: nothing channel-related during the framing bit
    a_r6_fbit_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAMING) |-> (!chan_strobe && !chan_block));

    // R8: multiframe pulses only in frame 1
    a_r8_mf_first: assert property (@(posedge clk) disable iff (rst)
        (mf_sync && sync_out) |-> (frm_idx == '0));
endmodule

// File: rtl/tx_chan_timing.sv
module tx_chan_timing
    import tct_pkg::*;
#(
    parameter int CH_BITS   = 8,
    parameter int T1_CHANS  = 24,
    parameter int E1_CHANS  = 32,
    parameter int T1_MF     = 24,
    parameter int E1_MF     = 16,
    parameter int SIG_EVERY = 6,
    localparam int BW       = $clog2(CH_BITS),
    localparam int CW       = $clog2(E1_CHANS),
    localparam int MF_MAX   = (T1_MF > E1_MF) ? T1_MF : E1_MF,
    localparam int FW       = $clog2(MF_MAX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                e1_mode,
    input  logic                sync_in,
    input  logic                gate_mode,
    input  logic                mf_sync,
    input  logic                wide_sig,
    input  logic [E1_CHANS-1:0] blk_mask,
    input  logic [E1_CHANS-1:0] frac_mask,
    output logic                chan_strobe,
    output logic                chan_block,
    output logic                sync_out
);
    tct_state_e    state;
    logic [BW-1:0] bit_idx;
    logic [CW-1:0] chan_idx;
    logic [FW-1:0] frm_idx;
    logic          frame_end;
    logic          sig_frame;

    tct_chan_ctr #(
        .CH_BITS (CH_BITS),
        .T1_CHANS(T1_CHANS),
        .E1_CHANS(E1_CHANS)
    ) u_chan (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .e1_mode  (e1_mode),
        .state    (state),
        .bit_idx  (bit_idx),
        .chan_idx (chan_idx),
        .frame_end(frame_end)
    );

    tct_frame_ctr #(
        .T1_MF    (T1_MF),
        .E1_MF    (E1_MF),
        .SIG_EVERY(SIG_EVERY)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .e1_mode  (e1_mode),
        .frame_end(frame_end),
        .frm_idx  (frm_idx),
        .sig_frame(sig_frame)
    );

    tct_strobe_gen #(
        .CH_BITS (CH_BITS),
        .E1_CHANS(E1_CHANS),
        .MF_MAX  (MF_MAX)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .bit_idx    (bit_idx),
        .chan_idx   (chan_idx),
        .frm_idx    (frm_idx),
        .sig_frame  (sig_frame),
        .e1_mode    (e1_mode),
        .gate_mode  (gate_mode),
        .mf_sync    (mf_sync),
        .wide_sig   (wide_sig),
        .blk_mask   (blk_mask),
        .frac_mask  (frac_mask),
        .chan_strobe(chan_strobe),
        .chan_block (chan_block),
        .sync_out   (sync_out)
    );

    // R3: in pulse mode two strobes never sit in adjacent cycles
    a_r3_strobe_isolated: assert property (@(posedge clk) disable iff (rst)
        (!gate_mode && chan_strobe) |=> (gate_mode || !chan_strobe));

    // R1: after a T1 sync pulse the framing bit carries the frame sync only
    a_r1_t1_reload_ports: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (e1_mode || (sync_out && !chan_strobe && !chan_block)));
endmodule

// File: tb/sim_tx_chan_timing.sv
module sim_tx_chan_timing;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        e1_mode = 1'b0;
    logic        sync_in = 1'b0;
    logic        gate_mode = 1'b0;
    logic        mf_sync = 1'b0;
    logic        wide_sig = 1'b0;
    logic [31:0] blk_mask = '0;
    logic [31:0] frac_mask = '0;
    logic        chan_strobe, chan_block, sync_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic s;
        logic b;
        logic y;
        int   pos;
        int   frm;
    } exp_t;
    exp_t q[$];

    int bpos = 0;
    int bfrm = 0;

    always #5 clk = ~clk;

    tx_chan_timing u0 (
        .clk(clk), .rst(rst), .e1_mode(e1_mode), .sync_in(sync_in),
        .gate_mode(gate_mode), .mf_sync(mf_sync), .wide_sig(wide_sig),
        .blk_mask(blk_mask), .frac_mask(frac_mask),
        .chan_strobe(chan_strobe), .chan_block(chan_block), .sync_out(sync_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // expected outputs from the requirements for a frame position
    function automatic exp_t model(input int pos, input int frm);
        exp_t e;
        int p, ch, b;
        e.pos = pos; e.frm = frm;
        e.s = 0; e.b = 0; e.y = 0;
        if (!e1_mode && pos == 0) begin
            e.s = 0; e.b = 0;
        end else begin
            p  = e1_mode ? pos : pos - 1;
            ch = p / 8;
            b  = p % 8;
            e.s = gate_mode ? frac_mask[ch] : (b == 7);
            e.b = blk_mask[ch];
        end
        if (mf_sync)
            e.y = (pos == 0) && (frm == 0);
        else
            e.y = (pos == 0) ||
                  (!e1_mode && wide_sig && pos == 1 && (frm % 6) == 5);
        return e;
    endfunction

    task automatic push_now();
        q.push_back(model(bpos, bfrm));
    endtask

    task automatic advance();
        int flen, mlen;
        flen = e1_mode ? 256 : 193;
        mlen = e1_mode ? 16 : 24;
        bpos++;
        if (bpos == flen) begin
            bpos = 0;
            bfrm = (bfrm + 1) % mlen;
        end
    endtask

    // driver: reload via reset or sync pulse, then predict each cycle
    task automatic restart(input bit via_sync);
        if (via_sync) sync_in = 1'b1; else rst = 1'b1;
        @(posedge clk);
        #1;
        sync_in = 1'b0;
        rst = 1'b0;
        bpos = 0;
        bfrm = 0;
        push_now();
    endtask

    task automatic run(input int n);
        for (int i = 1; i < n; i++) begin
            @(posedge clk);
            #1;
            advance();
            push_now();
        end
        @(posedge clk);
        #1;
    endtask

    // monitor: compare each produced cycle against the queued prediction
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (!e1_mode && e.pos == 0) begin
                check(chan_strobe == e.s, "R6 strobe", chan_strobe, e.s);
                check(chan_block == e.b, "R6 block", chan_block, e.b);
            end else begin
                if (!e1_mode && (frac_mask[31:24] != 0) && gate_mode)
                    check(chan_strobe == e.s, "R10 strobe", chan_strobe, e.s);
                else if (gate_mode)
                    check(chan_strobe == e.s, "R4 strobe", chan_strobe, e.s);
                else
                    check(chan_strobe == e.s, "R3 strobe", chan_strobe, e.s);
                if (!e1_mode && blk_mask[31:24] != 0)
                    check(chan_block == e.b, "R10 block", chan_block, e.b);
                else
                    check(chan_block == e.b, "R5 block", chan_block, e.b);
            end
            if (mf_sync)
                check(sync_out == e.y, "R8 sync", sync_out, e.y);
            else if (wide_sig)
                check(sync_out == e.y, "R9 sync", sync_out, e.y);
            else
                check(sync_out == e.y, "R7 sync", sync_out, e.y);
        end
    end

    task automatic measure_period(input int expect_len, input string tag);
        int cnt;
        @(negedge clk);
        while (!sync_out) @(negedge clk);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!sync_out && cnt < 400);
        check(cnt == expect_len, tag, cnt, expect_len);
    endtask

    task automatic configure(input bit e1, input bit g, input bit mf, input bit w,
                             input logic [31:0] bm, input logic [31:0] fm);
        rst = 1'b1;
        e1_mode = e1; gate_mode = g; mf_sync = mf; wide_sig = w;
        blk_mask = bm; frac_mask = fm;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;

        // R1 reset state, T1 pulse mode, frame sync
        configure(0, 0, 0, 0, 32'h0080_0F01, 32'h0);
        restart(0);
        @(negedge clk);
        check(sync_out == 1 && chan_strobe == 0 && chan_block == 0,
              "R1 T1 reset state", {sync_out, chan_strobe, chan_block}, 3'b100);
        run(2 * 193);

        // T1 gated mode, upper mask bits set (R10)
        configure(0, 1, 0, 0, 32'hFF00_00F3, 32'hAA55_3C81);
        restart(0);
        run(2 * 193);

        // T1 wide signaling sync with channel 0 overlap (R9)
        configure(0, 1, 0, 1, 32'h0000_0001, 32'h0000_0001);
        restart(0);
        run(24 * 193 + 10);

        // T1 multiframe sync, wide ignored (R8)
        configure(0, 0, 1, 1, 32'h0012_3456, 32'h0);
        restart(0);
        run(25 * 193);

        // E1 reset state and multiframe sync
        configure(1, 0, 1, 0, 32'h8000_0001, 32'h0);
        restart(0);
        @(negedge clk);
        check(sync_out == 1 && chan_block == 1 && chan_strobe == 0,
              "R1 E1 reset state", {sync_out, chan_strobe, chan_block}, 3'b101);
        run(17 * 256);

        // E1 gated, wide has no effect (R9)
        configure(1, 1, 0, 1, 32'hF0F0_0F0F, 32'hC000_0003);
        restart(0);
        run(2 * 256 + 5);

        // R1 external sync in the middle of a channel
        configure(0, 0, 0, 0, 32'h0000_0003, 32'h0);
        restart(0);
        run(100);
        restart(1);
        @(negedge clk);
        check(sync_out == 1 && chan_strobe == 0 && chan_block == 0,
              "R1 sync reload", {sync_out, chan_strobe, chan_block}, 3'b100);
        run(300);

        // R2 frame lengths
        configure(0, 0, 0, 0, 32'h0, 32'h0);
        restart(0);
        q.delete();
        measure_period(193, "R2 T1 frame length");
        configure(1, 0, 0, 0, 32'h0, 32'h0);
        restart(0);
        q.delete();
        measure_period(256, "R2 E1 frame length");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule